// File: doc/BRIEF.md
# E1 Basic Frame Aligner

This block watches a serial 2.048 Mb/s E1 receive stream one bit per clock and finds where each 256-bit frame begins. In time slot 0 it looks for the seven-bit alignment word. Consecutive frames alternate between frames that carry the word and frames that do not. The block confirms a candidate position over three frames before it declares lock. Once locked, it keeps checking the alignment word and drops lock when the word is corrupted too often. An optional rule also drops lock on repeated errors in the fixed bit of the frames that do not carry the word.

Downstream logic uses the lock flag, the per-frame start strobe and the bit and time-slot counters to pick channels out of the stream. A single-cycle loss pulse marks each drop of lock, so a later stage can count alarms. Multiframe alignment, line decoding and clock recovery are handled elsewhere.

Top module: `e1_frame_align`

## Requirements
- R1: The first received bit of a time slot is bit 1. Lock is declared only after three steps. First, bits 2 to 8 of time slot 0 equal 0011011 in frame N. Second, in frame N+1 that word is absent and bit 2 is 1. Third, the word is present again in frame N+2. `in_sync` rises after the clock edge that samples bit 8 of time slot 0 of frame N+2.
- R2: While locked, three consecutive word-bearing frames with a wrong alignment word drop lock. Lock drops after the edge that samples bit 8 of time slot 0 of the third bad frame. A correct word between bad frames restarts the count.
- R3: While `alt_resync` is 1 and lock is held, three consecutive non-word frames with bit 2 of time slot 0 equal to 0 drop lock. Lock drops after the edge that samples bit 8 of time slot 0 of the third such frame. A non-word frame with bit 2 equal to 1 restarts the count.
- R4: While `alt_resync` is 0, bit 2 errors in non-word frames never drop lock.
- R5: While locked, `ts_cnt` and `bit_cnt` give the time slot (0 to 31) and bit (0 to 7, bit 1 of the slot is 0) of the bit that the next clock edge samples.
- R6: `frame_start` is high for one cycle while locked, when the counters point at bit 0 of time slot 0.
- R7: `lof_pulse` is high for exactly the one cycle after lock is lost, and at that time `in_sync` is already low.
- R8: A failed check in frame N+1 or N+2 sends the block back to the bit-by-bit hunt from the bit after the failed check. The hunt fails if frame N+1 carries the word or has bit 2 equal to 0. It also fails if frame N+2 lacks the word.
- R9: After reset, `in_sync`, `lof_pulse` and `frame_start` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Received data bit, sampled each rising edge |
| alt_resync | input | 1 | 1 enables loss of lock on non-word bit 2 errors |
| in_sync | output | 1 | Frame lock held |
| lof_pulse | output | 1 | One-cycle loss-of-frame indication |
| frame_start | output | 1 | Start of frame strobe while locked |
| bit_cnt | output | 3 | Bit index within the time slot of the next sampled bit |
| ts_cnt | output | 5 | Time slot index of the next sampled bit |

## Verification
Lock changes and the loss pulse appear right after the edge that samples bit 8 of time slot 0 of the deciding frame. The strobe appears right after the edge that samples the last bit of a frame. The counters always name the next bit to be sampled. The driver builds whole frames and queues one expected record per bit it drives. Each record notes whether lock, loss and strobe are due after that bit's edge. The monitor takes one record 2 ns after each rising edge and compares it then, so every result is read exactly one register stage after the bit that causes it.

// File: rtl/e1fa_pkg.sv
package e1fa_pkg;

   localparam int FAS_LEN = 7;
   localparam logic [FAS_LEN-1:0] FAS_DEFAULT = 7'b0011011;

   typedef enum logic [1:0] {
      ST_HUNT     = 2'd0,
      ST_CHK_NFAS = 2'd1,
      ST_CHK_FAS  = 2'd2,
      ST_LOCKED   = 2'd3
   } e1fa_state_t;

endpackage

// File: rtl/e1fa_fas_window.sv
module e1fa_fas_window #(
   parameter int LEN = 7,
   parameter logic [LEN-1:0] PATTERN = 7'b0011011
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic hit,
   output logic lead_bit
);

   logic [LEN-1:0] win;

   generate
      if (LEN < 2) begin : g_bad_len
         $error("e1fa_fas_window: LEN must be at least 2");
      end
      else begin : g_shift
         logic [LEN-2:0] hist;
         always_ff @(posedge clk) begin
            if (!rst_n) hist <= '1;
            else        hist <= {hist[LEN-3 >= 0 ? LEN-3 : 0:0], din};
         end
         assign win = {hist, din};
      end
   endgenerate

   assign hit      = (win == PATTERN);
   assign lead_bit = win[LEN-1];

endmodule

// File: rtl/e1fa_pos_cnt.sv
module e1fa_pos_cnt #(
   parameter int FRAME_BITS = 256,
   parameter int TS_BITS    = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          load,
   input  logic [$clog2(FRAME_BITS)-1:0] load_val,
   output logic [$clog2(FRAME_BITS)-1:0] pos,
   output logic                          ts0_end,
   output logic                          frm_head
);

   localparam int PW = $clog2(FRAME_BITS);
   localparam logic [PW-1:0] LAST = PW'(FRAME_BITS - 1);
   localparam logic [PW-1:0] TS0_LAST = PW'(TS_BITS - 1);

   logic [PW-1:0] pos_inc;

   generate
      if ((1 << PW) == FRAME_BITS) begin : g_pow2_wrap
         assign pos_inc = pos + 1'b1;
      end
      else begin : g_cmp_wrap
         assign pos_inc = (pos == LAST) ? '0 : pos + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    pos <= '0;
      else if (load) pos <= load_val;
      else           pos <= pos_inc;
   end

   assign ts0_end  = (pos == TS0_LAST);
   assign frm_head = (pos == '0);

   // R5
   wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pos) == LAST && !$past(load)) |-> pos == '0);

endmodule

// File: rtl/e1fa_run_cnt.sv
module e1fa_run_cnt #(
   parameter int LIMIT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic valid,
   input  logic bad,
   output logic trip
);

   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

   logic [CW-1:0] cnt;

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("e1fa_run_cnt: LIMIT must be positive");
      end
   endgenerate

   assign trip = valid && bad && !clear && (cnt == TOP);

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt <= '0;
      else if (clear || trip) cnt <= '0;
      else if (valid)         cnt <= bad ? cnt + 1'b1 : '0;
   end

   // R2
   run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= TOP);

   // R2
   run_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !bad && !clear) |=> cnt == '0);

endmodule

// File: rtl/e1_frame_align.sv
module e1_frame_align #(
   parameter int FRAME_BITS    = 256,
   parameter int TS_BITS       = 8,
   parameter int LOSS_LIMIT    = 3,
   parameter bit ALT_RESYNC_EN = 1'b1,
   parameter logic [e1fa_pkg::FAS_LEN-1:0] FAS_WORD = e1fa_pkg::FAS_DEFAULT
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_bit,
   input  logic alt_resync,
   output logic in_sync,
   output logic lof_pulse,
   output logic frame_start,
   output logic [$clog2(TS_BITS)-1:0] bit_cnt,
   output logic [$clog2(FRAME_BITS)-$clog2(TS_BITS)-1:0] ts_cnt
);

   import e1fa_pkg::*;

   localparam int PW = $clog2(FRAME_BITS);
   localparam int BW = $clog2(TS_BITS);
   localparam logic [PW-1:0] AFTER_TS0 = PW'(TS_BITS % FRAME_BITS);

   generate
      if ((1 << BW) != TS_BITS) begin : g_bad_ts
         $error("e1_frame_align: TS_BITS must be a power of two");
      end
      if (FRAME_BITS % TS_BITS != 0 || FRAME_BITS < 2 * TS_BITS) begin : g_bad_frame
         $error("e1_frame_align: FRAME_BITS must hold several whole slots");
      end
      if (TS_BITS < FAS_LEN) begin : g_bad_word
         $error("e1_frame_align: slot shorter than alignment word");
      end
   endgenerate

   e1fa_state_t   state, state_n;
   logic          fas_exp, fas_exp_n;
   logic          lof_n;
   logic          load;
   logic          fas_hit, lead_bit;
   logic [PW-1:0] pos;
   logic          ts0_end, frm_head;
   logic          locked;
   logic          fas_trip, nf_trip;

   e1fa_fas_window #(.LEN(FAS_LEN), .PATTERN(FAS_WORD)) u_window (
      .clk      (clk),
      .rst_n    (rst_n),
      .din      (rx_bit),
      .hit      (fas_hit),
      .lead_bit (lead_bit)
   );

   e1fa_pos_cnt #(.FRAME_BITS(FRAME_BITS), .TS_BITS(TS_BITS)) u_pos (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (AFTER_TS0),
      .pos      (pos),
      .ts0_end  (ts0_end),
      .frm_head (frm_head)
   );

   assign locked = (state == ST_LOCKED);

   e1fa_run_cnt #(.LIMIT(LOSS_LIMIT)) u_fas_err (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (!locked),
      .valid (locked && ts0_end && fas_exp),
      .bad   (!fas_hit),
      .trip  (fas_trip)
   );

   generate
      if (ALT_RESYNC_EN) begin : g_alt
         e1fa_run_cnt #(.LIMIT(LOSS_LIMIT)) u_nf_err (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (!locked || !alt_resync),
            .valid (locked && ts0_end && !fas_exp),
            .bad   (!lead_bit),
            .trip  (nf_trip)
         );
      end
      else begin : g_no_alt
         logic unused_alt;
         assign unused_alt = alt_resync;
         assign nf_trip    = 1'b0;
      end
   endgenerate

   always_comb begin
      state_n   = state;
      fas_exp_n = fas_exp;
      lof_n     = 1'b0;
      load      = 1'b0;
      case (state)
         ST_HUNT: begin
            if (fas_hit) begin
               load    = 1'b1;
               state_n = ST_CHK_NFAS;
            end
         end
         ST_CHK_NFAS: begin
            if (ts0_end) state_n = (!fas_hit && lead_bit) ? ST_CHK_FAS : ST_HUNT;
         end
         ST_CHK_FAS: begin
            if (ts0_end) begin
               if (fas_hit) begin
                  state_n   = ST_LOCKED;
                  fas_exp_n = 1'b0;
               end
               else begin
                  state_n = ST_HUNT;
               end
            end
         end
         ST_LOCKED: begin
            if (ts0_end) begin
               fas_exp_n = !fas_exp;
               if (fas_trip || nf_trip) begin
                  state_n = ST_HUNT;
                  lof_n   = 1'b1;
               end
            end
         end
         default: state_n = ST_HUNT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_HUNT;
         fas_exp   <= 1'b0;
         lof_pulse <= 1'b0;
      end
      else begin
         state     <= state_n;
         fas_exp   <= fas_exp_n;
         lof_pulse <= lof_n;
      end
   end

   assign in_sync     = locked;
   assign frame_start = locked && frm_head;
   assign bit_cnt     = pos[BW-1:0];
   assign ts_cnt      = pos[PW-1:BW];

   // R1
   sync_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_sync) |-> ($past(state) == ST_CHK_FAS && $past(fas_hit)));

   // R7
   lof_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lof_pulse |=> !lof_pulse);

   // R7
   lof_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lof_pulse |-> (!in_sync && $past(in_sync)));

   // R4
   alt_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lof_pulse && !$past(alt_resync)) |-> $past(!fas_hit));

   // R6
   strobe_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> (in_sync && $past(in_sync)));

endmodule

// File: tb/e1_frame_align_tb.sv
module e1_frame_align_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_bit = 1'b1;
   logic       alt_resync = 1'b0;
   logic       in_sync, lof_pulse, frame_start;
   logic [2:0] bit_cnt;
   logic [4:0] ts_cnt;

   localparam int K_FAS = 0;  // 1 0011011
   localparam int K_BADF = 1; // word-bearing frame, corrupted word
   localparam int K_NF = 2;   // non-word frame, bit 2 = 1
   localparam int K_NFB = 3;  // non-word frame, bit 2 = 0
   localparam int E_NONE = 0, E_GAIN = 1, E_LOSE = 2;

   always #5 clk = ~clk;

   e1_frame_align u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_bit      (rx_bit),
      .alt_resync  (alt_resync),
      .in_sync     (in_sync),
      .lof_pulse   (lof_pulse),
      .frame_start (frame_start),
      .bit_cnt     (bit_cnt),
      .ts_cnt      (ts_cnt)
   );

   typedef struct packed {
      logic       s;
      logic       l;
      logic       f;
      logic       pk;
      logic [7:0] pos;
   } exp_t;

   exp_t  q[$];
   string tq[$];
   int    vectors = 0;
   int    miscompares = 0;
   logic  exp_sync = 1'b0;
   string tag = "R9";
   bit    done = 1'b0;

   task automatic push_bit(input logic b, input logic lof_now, input logic [7:0] p);
      exp_t e;
      @(negedge clk);
      rx_bit = b;
      e.s   = exp_sync;
      e.l   = lof_now;
      e.f   = exp_sync && (p == 8'd0);
      e.pk  = exp_sync;
      e.pos = p;
      q.push_back(e);
      tq.push_back(tag);
   endtask

   task automatic send_junk(input int n);
      for (int i = 0; i < n; i++) push_bit(1'b1, 1'b0, 8'd0);
   endtask

   task automatic send_frame(input int kind, input int evt);
      logic [7:0] b0;
      logic       bb, ll;
      case (kind)
         K_FAS:   b0 = 8'b1001_1011;
         K_BADF:  b0 = 8'b1001_1111;
         K_NF:    b0 = 8'b1101_1111;
         default: b0 = 8'b1001_1111;
      endcase
      for (int i = 0; i < 256; i++) begin
         bb = (i < 8) ? b0[7-i] : 1'b1;
         ll = 1'b0;
         if (i == 7 && evt == E_GAIN) exp_sync = 1'b1;
         if (i == 7 && evt == E_LOSE) begin
            exp_sync = 1'b0;
            ll = 1'b1;
         end
         push_bit(bb, ll, 8'((i + 1) % 256));
      end
   endtask

   task automatic check_now(input string t, input logic s, input logic l, input logic f);
      vectors++;
      if (in_sync !== s || lof_pulse !== l || frame_start !== f) begin
         miscompares++;
         $display("FAIL %s: got sync/lof/start %b%b%b expected %b%b%b",
                  t, in_sync, lof_pulse, frame_start, s, l, f);
      end
   endtask

   // monitor: one queued record per sampled bit
   initial begin
      exp_t  e;
      string t;
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            e = q.pop_front();
            t = tq.pop_front();
            vectors++;
            if (in_sync !== e.s || lof_pulse !== e.l || frame_start !== e.f ||
                (e.pk && {ts_cnt, bit_cnt} !== e.pos)) begin
               miscompares++;
               $display("FAIL %s: got sync=%b lof=%b start=%b pos=%0d expected sync=%b lof=%b start=%b pos=%0d",
                        t, in_sync, lof_pulse, frame_start, {ts_cnt, bit_cnt},
                        e.s, e.l, e.f, e.pos);
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state
      check_now("R9", 1'b0, 1'b0, 1'b0);

      // R1: hunt through idle ones, then three-frame verification
      tag = "R1";
      send_junk(37);
      send_frame(K_FAS, E_NONE);
      send_frame(K_NF, E_NONE);
      send_frame(K_FAS, E_GAIN);

      // R5 R6: counters and strobe while locked
      tag = "R5_R6";
      send_frame(K_NF, E_NONE);
      send_frame(K_FAS, E_NONE);
      send_frame(K_NF, E_NONE);
      send_frame(K_FAS, E_NONE);

      // R4: bit 2 errors ignored while alt mode is off
      tag = "R4";
      for (int k = 0; k < 4; k++) begin
         send_frame(K_NFB, E_NONE);
         send_frame(K_FAS, E_NONE);
      end

      // R2: two bad words, a good one restarts the run, then three in a row; R7 pulse
      tag = "R2_R7";
      send_frame(K_NF, E_NONE);
      send_frame(K_BADF, E_NONE);
      send_frame(K_NF, E_NONE);
      send_frame(K_BADF, E_NONE);
      send_frame(K_NF, E_NONE);
      send_frame(K_FAS, E_NONE);
      send_frame(K_NF, E_NONE);
      send_frame(K_BADF, E_NONE);
      send_frame(K_NF, E_NONE);
      send_frame(K_BADF, E_NONE);
      send_frame(K_NF, E_NONE);
      send_frame(K_BADF, E_LOSE);

      // R8: failed N+1 (bit 2 low), failed N+2 (no word), failed N+1 (word present)
      tag = "R8";
      send_frame(K_NF, E_NONE);
      send_frame(K_FAS, E_NONE);
      send_frame(K_NFB, E_NONE);
      send_frame(K_FAS, E_NONE);
      send_frame(K_NF, E_NONE);
      send_frame(K_BADF, E_NONE);
      send_frame(K_NF, E_NONE);
      send_frame(K_FAS, E_NONE);
      send_frame(K_FAS, E_NONE);
      send_frame(K_NF, E_NONE);
      send_frame(K_FAS, E_NONE);
      send_frame(K_NF, E_NONE);
      send_frame(K_FAS, E_GAIN);

      // R3: alt mode, two bad bit 2, restart, then three in a row
      tag = "R3_R7";
      alt_resync = 1'b1;
      send_frame(K_NF, E_NONE);
      send_frame(K_FAS, E_NONE);
      send_frame(K_NFB, E_NONE);
      send_frame(K_FAS, E_NONE);
      send_frame(K_NFB, E_NONE);
      send_frame(K_FAS, E_NONE);
      send_frame(K_NF, E_NONE);
      send_frame(K_FAS, E_NONE);
      send_frame(K_NFB, E_NONE);
      send_frame(K_FAS, E_NONE);
      send_frame(K_NFB, E_NONE);
      send_frame(K_FAS, E_NONE);
      send_frame(K_NFB, E_LOSE);
      send_junk(4);

      while (q.size() > 0) @(posedge clk);
      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule